// File: doc/BRIEF.md
# Burst-Mode AMI Line Framer

This block is the digital core at the timing-master end of a time-compression-multiplexed two-wire loop. On every second 8 kHz frame tick it opens a burst. The burst is a framing mark followed by 36 scrambled payload bits, which carry the B1, B2 and D channel data of two frames. Each bit goes out as a ternary AMI symbol, one symbol per strobe of the symbol-rate enable. The block then listens for the reply from the far end. The reply is a start mark followed by 36 AMI symbols. The block descrambles it, delivers it as one parallel word, and flags any polarity-rule violation in that reply.

A four-period rule turns framing results into a loop-sync flag. Until sync is held, the transmitted payload is forced to all ones. This is the wake-up pattern the far end needs to lock on. Dropping the line-enable input returns the block to a quiet, reinitialised state.

Top module: `burst_ami_framer`

## Requirements
- R1: While `line_up` is low (and after reset), `tx_sym` is 00, `line_sync` is 0 and `rx_valid` is 0. Raising `line_up` again restarts with both scramblers at all ones and with the next mark sent positive.
- R2: After activation, frame ticks alternate between capture-only and burst-start, beginning with capture-only. A burst sends exactly 37 symbols, one per `sym_en`, starting with the first `sym_en` after the burst-start tick. `tx_sym` is 00 on every other `sym_en`. A `sym_en` in the burst-start cycle itself is ignored by both directions.
- R3: The first symbol of a burst is always a mark that bypasses the scrambler. Its polarity is opposite to the last mark of the previous burst.
- R4: Symbol codes are 01 for a positive mark, 11 for a negative mark and 00 for no pulse. Transmitted ones are marks of strictly alternating polarity, and zeros are 00.
- R5: Each payload bit d is sent as s = d xor s(t-5) xor s(t-9), where s is the history of transmitted scrambled bits. The receiver inverts this using the history of received bits. Only payload symbols advance either history.
- R6: The payload order is frame-1 B1, B2, D, then frame-2 B1, B2, D, each MSB first. Frame data is sampled on the frame tick. `rx_payload` uses the same order, with the first received bit in bit 35.
- R7: While `line_sync` is 0 at burst start, the 36 payload bits sent are all ones.
- R8: Symbols on `rx_sym` are ignored while the block's own burst is being sent.
- R9: The first mark heard after the own burst is taken as the far-end start mark, and the next 36 symbols are its payload. `rx_valid` pulses for one cycle after the 36th payload symbol. Further symbols in that burst period are ignored.
- R10: Two consecutive marks of equal polarity, from the start mark through the payload, set `rx_bpv` together with that burst's `rx_valid`.
- R11: `line_sync` rises after 4 consecutive burst periods that each delivered a complete reply. It changes only in the cycle after a burst start.
- R12: `line_sync` falls after 4 consecutive burst periods without a complete reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_up | input | 1 | Line enable; low keeps the line deactivated |
| frame_tick | input | 1 | One-cycle 8 kHz frame tick |
| sym_en | input | 1 | One-cycle symbol-rate strobe |
| tx_b1 | input | 8 | B1 octet for the current frame |
| tx_b2 | input | 8 | B2 octet for the current frame |
| tx_d | input | 2 | D bits for the current frame |
| rx_sym | input | 2 | Received ternary symbol |
| tx_sym | output | 2 | Transmitted ternary symbol |
| rx_payload | output | 36 | Descrambled payload of the last reply |
| rx_valid | output | 1 | One-cycle pulse: rx_payload updated |
| rx_bpv | output | 1 | Bipolar violation in that reply |
| line_sync | output | 1 | Loop synchronised |

## Verification
Two situations are hard to reach from the ports. The first is loss of sync: the loop must first hold sync through four good periods and then see four consecutive periods with no reply. The second is a bipolar violation, which needs a far end that deliberately repeats a mark polarity in the middle of a correctly scrambled reply. The bench therefore plays the far-end transceiver with its own scrambler and polarity state. Per burst it chooses a normal reply, a silent period, a reply with one repeated-polarity mark, or marks injected during the block's own burst. Each own burst is also decoded by that same far end, which checks the start-mark polarity and the descrambled payload against the frame data it supplied.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_DATA = 2'd1,
    RX_DONE = 2'd2
  } rx_state_t;
endpackage

// File: rtl/bmf_tx.sv
module bmf_tx
  import bmf_pkg::*;
#(
  parameter int PAY_W   = 36,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_up,
  input  logic             burst_go,
  input  logic             sym_en,
  input  logic [PAY_W-1:0] payload,
  output logic [1:0]       tx_sym,
  output logic             busy
);
  localparam int IDX_W = $clog2(PAY_W + 2);

  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [PAY_W-1:0]   sh_q, sh_d;
  logic [SCR_LEN-1:0] scr_q, scr_d;
  logic               neg_q, neg_d;
  logic               busy_d;
  logic [1:0]         sym_d;
  logic               bit_c;

  always_comb begin
    idx_d  = idx_q;
    sh_d   = sh_q;
    scr_d  = scr_q;
    neg_d  = neg_q;
    busy_d = busy;
    sym_d  = tx_sym;
    bit_c  = 1'b0;
    if (!line_up) begin
      idx_d  = '0;
      sh_d   = '0;
      scr_d  = '1;
      neg_d  = 1'b1;
      busy_d = 1'b0;
      sym_d  = SYM_ZERO;
    end else if (burst_go) begin
      idx_d  = '0;
      sh_d   = payload;
      busy_d = 1'b1;
      sym_d  = SYM_ZERO;
    end else if (sym_en) begin
      if (busy) begin
        if (idx_q == '0) begin
          bit_c = 1'b1;
        end else begin
          bit_c = sh_q[PAY_W-1] ^ scr_q[SCR_LEN-1] ^ scr_q[SCR_TAP-1];
          scr_d = {scr_q[SCR_LEN-2:0], bit_c};
          sh_d  = {sh_q[PAY_W-2:0], 1'b0};
        end
        if (bit_c) begin
          sym_d = neg_q ? SYM_POS : SYM_NEG;
          neg_d = ~neg_q;
        end else begin
          sym_d = SYM_ZERO;
        end
        if (idx_q == IDX_W'(PAY_W)) busy_d = 1'b0;
        idx_d = idx_q + 1'b1;
      end else begin
        sym_d = SYM_ZERO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sh_q   <= '0;
      scr_q  <= '1;
      neg_q  <= 1'b1;
      busy   <= 1'b0;
      tx_sym <= SYM_ZERO;
    end else begin
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      scr_q  <= scr_d;
      neg_q  <= neg_d;
      busy   <= busy_d;
      tx_sym <= sym_d;
    end
  end
endmodule

// File: rtl/bmf_rx.sv
module bmf_rx
  import bmf_pkg::*;
#(
  parameter int PAY_W   = 36,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_up,
  input  logic             burst_go,
  input  logic             sym_en,
  input  logic             listen,
  input  logic [1:0]       rx_sym,
  output logic [PAY_W-1:0] rx_payload,
  output logic             rx_valid,
  output logic             rx_bpv,
  output logic             frame_ok
);
  localparam int CNT_W = $clog2(PAY_W + 1);

  rx_state_t          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [PAY_W-1:0]   sh_q, sh_d, pay_d;
  logic [SCR_LEN-1:0] dsc_q, dsc_d;
  logic               neg_q, neg_d, viol_q, viol_d;
  logic               valid_d, bpv_d, ok_d;
  logic               mark, is_neg, dbit;

  assign mark   = (rx_sym == SYM_POS) || (rx_sym == SYM_NEG);
  assign is_neg = (rx_sym == SYM_NEG);
  assign dbit   = mark ^ dsc_q[SCR_LEN-1] ^ dsc_q[SCR_TAP-1];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    pay_d   = rx_payload;
    dsc_d   = dsc_q;
    neg_d   = neg_q;
    viol_d  = viol_q;
    ok_d    = frame_ok;
    valid_d = 1'b0;
    bpv_d   = 1'b0;
    if (!line_up) begin
      st_d   = RX_HUNT;
      cnt_d  = '0;
      sh_d   = '0;
      dsc_d  = '1;
      neg_d  = 1'b0;
      viol_d = 1'b0;
      ok_d   = 1'b0;
    end else if (burst_go) begin
      st_d   = RX_HUNT;
      viol_d = 1'b0;
      ok_d   = 1'b0;
    end else if (sym_en && listen) begin
      case (st_q)
        RX_HUNT: begin
          if (mark) begin
            st_d   = RX_DATA;
            cnt_d  = '0;
            neg_d  = is_neg;
            viol_d = 1'b0;
          end
        end
        RX_DATA: begin
          if (mark) begin
            if (is_neg == neg_q) viol_d = 1'b1;
            neg_d = is_neg;
          end
          dsc_d = {dsc_q[SCR_LEN-2:0], mark};
          sh_d  = {sh_q[PAY_W-2:0], dbit};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(PAY_W - 1)) begin
            st_d    = RX_DONE;
            ok_d    = 1'b1;
            valid_d = 1'b1;
            pay_d   = {sh_q[PAY_W-2:0], dbit};
            bpv_d   = viol_d;
          end
        end
        default: st_d = RX_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RX_HUNT;
      cnt_q      <= '0;
      sh_q       <= '0;
      rx_payload <= '0;
      dsc_q      <= '1;
      neg_q      <= 1'b0;
      viol_q     <= 1'b0;
      frame_ok   <= 1'b0;
      rx_valid   <= 1'b0;
      rx_bpv     <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      rx_payload <= pay_d;
      dsc_q      <= dsc_d;
      neg_q      <= neg_d;
      viol_q     <= viol_d;
      frame_ok   <= ok_d;
      rx_valid   <= valid_d;
      rx_bpv     <= bpv_d;
    end
  end
endmodule

// File: rtl/bmf_sync.sv
module bmf_sync #(
  parameter int SYNC_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_up,
  input  logic burst_go,
  input  logic frame_ok,
  output logic line_sync
);
  localparam int CNT_W = $clog2(SYNC_N + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_d;
  logic             hit, last;

  assign hit  = (frame_ok != line_sync);
  assign last = (cnt_q == CNT_W'(SYNC_N - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sync_d = line_sync;
    if (!line_up) begin
      cnt_d  = '0;
      sync_d = 1'b0;
    end else if (burst_go) begin
      if (!hit) begin
        cnt_d = '0;
      end else if (last) begin
        cnt_d  = '0;
        sync_d = ~line_sync;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      line_sync <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      line_sync <= sync_d;
    end
  end
endmodule

// File: rtl/burst_ami_framer.sv
module burst_ami_framer #(
  parameter int B_W     = 8,
  parameter int D_W     = 2,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5,
  parameter int SYNC_N  = 4,
  localparam int FRM_W  = 2 * B_W + D_W,
  localparam int PAY_W  = 2 * FRM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_up,
  input  logic             frame_tick,
  input  logic             sym_en,
  input  logic [B_W-1:0]   tx_b1,
  input  logic [B_W-1:0]   tx_b2,
  input  logic [D_W-1:0]   tx_d,
  input  logic [1:0]       rx_sym,
  output logic [1:0]       tx_sym,
  output logic [PAY_W-1:0] rx_payload,
  output logic             rx_valid,
  output logic             rx_bpv,
  output logic             line_sync
);
  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             phase_q, phase_d;
  logic [FRM_W-1:0] hold_q, hold_d;
  logic             burst_go, tx_busy, frame_ok;
  logic [PAY_W-1:0] tx_payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign burst_go   = line_up & frame_tick & phase_q;
  assign tx_payload = line_sync ? {hold_q, tx_b1, tx_b2, tx_d} : '1;

  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    if (!line_up) begin
      phase_d = 1'b0;
    end else if (frame_tick) begin
      phase_d = ~phase_q;
      if (!phase_q) hold_d = {tx_b1, tx_b2, tx_d};
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
    end
  end

  bmf_tx #(.PAY_W(PAY_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .line_up(line_up), .burst_go(burst_go),
    .sym_en(sym_en), .payload(tx_payload), .tx_sym(tx_sym), .busy(tx_busy)
  );

  bmf_rx #(.PAY_W(PAY_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .line_up(line_up), .burst_go(burst_go),
    .sym_en(sym_en), .listen(~tx_busy), .rx_sym(rx_sym),
    .rx_payload(rx_payload), .rx_valid(rx_valid), .rx_bpv(rx_bpv), .frame_ok(frame_ok)
  );

  bmf_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .line_up(line_up), .burst_go(burst_go),
    .frame_ok(frame_ok), .line_sync(line_sync)
  );
endmodule

// File: rtl/bmf_checker.sv
module bmf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_up,
  input logic       burst_go,
  input logic       tx_busy,
  input logic [1:0] tx_sym,
  input logic       rx_valid,
  input logic       rx_bpv,
  input logic       line_sync
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !line_up |=> (tx_sym == 2'b00 && !line_sync && !rx_valid));

  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym != 2'b10);

  a_r2_burst_opens_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> (tx_busy && tx_sym == 2'b00));

  a_r8_deaf_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !rx_valid);

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r10_bpv_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bpv |-> rx_valid);

  a_r11_sync_on_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_sync) |-> ($past(burst_go) || !$past(line_up)));
endmodule

bind burst_ami_framer bmf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .line_up(line_up), .burst_go(burst_go),
  .tx_busy(tx_busy), .tx_sym(tx_sym), .rx_valid(rx_valid), .rx_bpv(rx_bpv),
  .line_sync(line_sync)
);

// File: tb/burst_ami_framer_tb.sv
module burst_ami_framer_tb;
  localparam int FRAME_CYC = 192;
  localparam logic [1:0] POS = 2'b01;
  localparam logic [1:0] NEG = 2'b11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, line_up, frame_tick, sym_en;
  logic [7:0]  tx_b1, tx_b2;
  logic [1:0]  tx_d, rx_sym;
  logic [1:0]  tx_sym;
  logic [35:0] rx_payload;
  logic        rx_valid, rx_bpv, line_sync;

  burst_ami_framer u_dut (
    .clk(clk), .rst_n(rst_n), .line_up(line_up), .frame_tick(frame_tick),
    .sym_en(sym_en), .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_d(tx_d), .rx_sym(rx_sym),
    .tx_sym(tx_sym), .rx_payload(rx_payload), .rx_valid(rx_valid),
    .rx_bpv(rx_bpv), .line_sync(line_sync)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model (behavioural) ----------------
  int        m_phase, m_rstate, m_rcnt, m_scnt;
  bit [17:0] m_hold;
  bit        mq[$];
  bit        m_busy, m_first, m_txneg, m_rneg, m_viol, m_done, m_valid, m_bpv, m_sync;
  bit [8:0]  m_scr, m_dscr;
  bit [1:0]  m_sym;
  bit [35:0] m_sh, m_pay;

  always @(posedge clk) begin
    bit go, mk, ng, d, b;
    bit [35:0] pay;
    if (!line_up) begin
      m_phase = 0; mq.delete(); m_busy = 0; m_first = 0; m_txneg = 1; m_scr = '1;
      m_sym = 0; m_rstate = 0; m_rcnt = 0; m_dscr = '1; m_done = 0; m_valid = 0;
      m_bpv = 0; m_sync = 0; m_scnt = 0; m_viol = 0;
    end else begin
      go = frame_tick && (m_phase == 1);
      m_valid = 0; m_bpv = 0;
      if (go) begin
        pay = m_sync ? {m_hold, tx_b1, tx_b2, tx_d} : '1;
        if (m_done != m_sync) begin
          m_scnt++;
          if (m_scnt == 4) begin m_sync = !m_sync; m_scnt = 0; end
        end else m_scnt = 0;
        mq.delete();
        for (int i = 35; i >= 0; i--) mq.push_back(pay[i]);
        m_first = 1; m_busy = 1; m_sym = 0; m_rstate = 0; m_done = 0; m_viol = 0;
      end else if (sym_en) begin
        if (!m_busy && m_rstate != 2) begin
          mk = (rx_sym == POS) || (rx_sym == NEG);
          ng = (rx_sym == NEG);
          if (m_rstate == 0) begin
            if (mk) begin m_rstate = 1; m_rcnt = 0; m_rneg = ng; m_viol = 0; end
          end else begin
            if (mk) begin
              if (ng == m_rneg) m_viol = 1;
              m_rneg = ng;
            end
            d = mk ^ m_dscr[8] ^ m_dscr[4];
            m_dscr = {m_dscr[7:0], mk};
            m_sh = {m_sh[34:0], d};
            m_rcnt++;
            if (m_rcnt == 36) begin
              m_rstate = 2; m_done = 1; m_valid = 1; m_pay = m_sh; m_bpv = m_viol;
            end
          end
        end
        if (m_busy) begin
          if (m_first) begin b = 1; m_first = 0; end
          else begin
            b = mq.pop_front() ^ m_scr[8] ^ m_scr[4];
            m_scr = {m_scr[7:0], b};
          end
          if (b) begin m_sym = m_txneg ? POS : NEG; m_txneg = !m_txneg; end
          else m_sym = 0;
          if (mq.size() == 0) m_busy = 0;
        end else m_sym = 0;
      end
      if (frame_tick) begin
        if (m_phase == 0) m_hold = {tx_b1, tx_b2, tx_d};
        m_phase = 1 - m_phase;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_sym == m_sym, "R4 tx symbol vs model", tx_sym, m_sym);
      chk(rx_valid == m_valid, "R9 rx_valid vs model", rx_valid, m_valid);
      if (m_valid) chk(rx_payload == m_pay, "R6 rx_payload vs model", rx_payload, m_pay);
      chk(rx_bpv == m_bpv, "R10 rx_bpv vs model", rx_bpv, m_bpv);
      chk(line_sync == m_sync, "R11 line_sync vs model", line_sync, m_sync);
    end
  end

  // ---------------- stimulus and far-end emulation ----------------
  int        cyc = 0;
  bit        tick_odd, go_now, prev_sym_en, got_valid, got_bpv;
  bit [17:0] f_prev, f_cur;
  bit [35:0] got_pay;
  logic [1:0] plan[$];
  logic [1:0] txrec[$];
  bit        b_txneg, r_neg;
  bit [8:0]  b_dscr, r_scr;
  bit        sync_after;

  task automatic step();
    @(negedge clk);
    if (prev_sym_en && txrec.size() < 37) txrec.push_back(tx_sym);
    if (rx_valid) begin got_valid = 1; got_pay = rx_payload; got_bpv = rx_bpv; end
    cyc++;
    sym_en = (cyc % 4 == 0);
    frame_tick = line_up && (cyc % FRAME_CYC == 2);
    go_now = 0;
    if (frame_tick) begin
      f_prev = f_cur;
      f_cur = 18'($urandom);
      {tx_b1, tx_b2, tx_d} = f_cur;
      if (tick_odd) go_now = 1;
      tick_odd = !tick_odd;
    end
    if (sym_en) rx_sym = (plan.size() != 0) ? plan.pop_front() : 2'b00;
    prev_sym_en = sym_en;
  endtask

  task automatic fresh_line();
    tick_odd = 0; b_txneg = 1; b_dscr = '1; r_scr = '1; r_neg = 1; plan.delete();
  endtask

  // mode: 0 normal reply, 1 silent, 2 reply with violation, 3 marks during own burst
  task automatic run_burst(input int mode);
    bit        sync_before, first_mark, mk, d, s;
    bit [35:0] exp_tx, exp_rx, got_tx;
    bit [1:0]  sy;
    do step(); while (!go_now);
    sync_before = line_sync;
    exp_tx = sync_before ? {f_prev, f_cur} : '1;
    plan.delete(); txrec.delete(); got_valid = 0;
    for (int i = 0; i < 37; i++) plan.push_back(mode == 3 ? ((i % 2) ? POS : POS) : 2'b00);
    for (int i = 0; i < 8; i++) plan.push_back(2'b00);
    exp_rx = {4'($urandom), 32'($urandom)};
    if (mode != 1) begin
      plan.push_back(r_neg ? POS : NEG);
      r_neg = !r_neg;
      first_mark = 1;
      for (int i = 35; i >= 0; i--) begin
        s = exp_rx[i] ^ r_scr[8] ^ r_scr[4];
        r_scr = {r_scr[7:0], s};
        if (!s) plan.push_back(2'b00);
        else if (mode == 2 && first_mark) begin
          plan.push_back(r_neg ? NEG : POS);
          first_mark = 0;
        end else begin
          plan.push_back(r_neg ? POS : NEG);
          r_neg = !r_neg;
        end
      end
    end
    step();
    sync_after = line_sync;
    for (int k = 0; k < 2 * FRAME_CYC - 9; k++) step();
    // own burst decoded by the far end
    chk(txrec.size() == 37, "R2 burst length", txrec.size(), 37);
    if (txrec.size() == 37) begin
      chk(txrec[0] == (b_txneg ? POS : NEG), "R3 start mark polarity", txrec[0], b_txneg ? POS : NEG);
      got_tx = '0;
      for (int i = 0; i < 37; i++) begin
        sy = txrec[i];
        mk = (sy != 2'b00);
        if (mk) begin
          if (i > 0) chk(sy == (b_txneg ? POS : NEG), "R4 alternating marks", sy, b_txneg ? POS : NEG);
          b_txneg = (sy == NEG);
        end
        if (i > 0) begin
          d = mk ^ b_dscr[8] ^ b_dscr[4];
          b_dscr = {b_dscr[7:0], mk};
          got_tx = {got_tx[34:0], d};
        end
      end
      if (sync_before) chk(got_tx == exp_tx, "R5 R6 sent payload", got_tx, exp_tx);
      else             chk(got_tx == exp_tx, "R7 wake-up all ones", got_tx, exp_tx);
    end
    if (mode == 1) begin
      chk(!got_valid, "R9 no frame when silent", got_valid, 0);
    end else begin
      chk(got_valid, "R9 reply delivered", got_valid, 1);
      if (mode == 3) chk(got_pay == exp_rx, "R8 marks during own burst ignored", got_pay, exp_rx);
      else           chk(got_pay == exp_rx, "R5 R9 received payload", got_pay, exp_rx);
      chk(got_bpv == (mode == 2), "R10 violation flag", got_bpv, mode == 2);
    end
  endtask

  initial begin
    rst_n = 0; line_up = 0; frame_tick = 0; sym_en = 0; rx_sym = 0;
    tx_b1 = 0; tx_b2 = 0; tx_d = 0;
    fresh_line();
    repeat (5) step();
    rst_n = 1;
    repeat (10) step();
    chk(tx_sym == 2'b00 && !line_sync && !rx_valid, "R1 reset state", {tx_sym, line_sync, rx_valid}, 0);
    line_up = 1;
    for (int b = 0; b < 15; b++) begin
      int mode;
      mode = (b == 6) ? 2 : (b == 7) ? 3 : (b >= 8 && b <= 12) ? 1 : 0;
      run_burst(mode);
      if (b == 3)  chk(!sync_after, "R11 not yet synced after 3 good", sync_after, 0);
      if (b == 4)  chk(sync_after,  "R11 synced after 4 good", sync_after, 1);
      if (b == 11) chk(sync_after,  "R12 sync held after 3 missing", sync_after, 1);
      if (b == 12) chk(!sync_after, "R12 sync lost after 4 missing", sync_after, 0);
    end
    line_up = 0;
    plan.delete();
    repeat (20) step();
    chk(tx_sym == 2'b00 && !line_sync && !rx_valid, "R1 deactivated quiet", {tx_sym, line_sync, rx_valid}, 0);
    fresh_line();
    line_up = 1;
    for (int b = 0; b < 6; b++) begin
      run_burst(0);
      if (b == 4) chk(sync_after, "R1 R11 resync after reactivation", sync_after, 1);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule